// File: doc/BRIEF.md
# Host Memory Access Port

This block lets an external host reach a processor's on-chip program memory (PM) and data memory (DM) over one 16-bit bus. The same bus carries addresses and data at different times. The host drives four strobes: select, latch, read and write. The strobes need not be related to the processor clock, so each one passes through a synchronizer before the port acts on it. The port reports on an acknowledge line whether it is free to take a new cycle.

A latch cycle writes one control word into the port. When the top bit of the word is clear, the word gives a start address and a memory type. When the top bit is set, the word gives an overlay selection instead. Later read and write strobes access memory through a single-port RAM interface. The address steps forward by itself, so the host sends only the first address of a block. A PM word is 24 bits wide and takes two bus cycles.

A boot input can make the port hold the core in a stopped state after reset. The core stays stopped until the host has fully written PM location 0.

Top module: `host_mem_port`

## Requirements
- R1: After reset, `h_ack` is 1, `h_ovl` is 0 and `h_ad_out` is 0. `core_run` is 0 whenever `boot_host` is 1.
- R2: A latch cycle is select high while latch falls. If bit 15 of the word is 0, bits 13:0 become the access address and bit 14 becomes the memory type (1 = DM, 0 = PM). The latch cycle also restarts the PM word pairing.
- R3: A latch word with bit 15 = 1 and bits 14:8 all zero loads bits 7:0 into `h_ovl`. The access address is left unchanged.
- R4: A latch word with bit 15 = 1 and any of bits 14:8 nonzero has no effect. Both `h_ovl` and the access address keep their values.
- R5: In DM mode, each write stores bus bits 15:0 at the current address. Each read returns the stored 16 bits. Each DM access then advances the address by one.
- R6: In PM mode, a 24-bit word takes two bus cycles: bits 23:8 first, then bits 7:0 in bus bits 7:0. A read's second cycle returns the low byte with bus bits 15:8 at zero. The address advances only after the second cycle.
- R7: `h_ack` goes low once a synchronized read or write strobe is detected. It stays low until the access completes, which is within 8 clocks of the strobe's rise. `h_ack` is low whenever `mem_req` is high.
- R8: `mem_req` is a single-cycle pulse. Each DM access issues exactly one request. A PM write issues one request, on its second cycle only. A PM read issues one request, on its first cycle only.
- R9: With `boot_host` at 1, `core_run` stays 0 until the second cycle of a PM write to address 0 completes. It then stays at 1 until reset.
- R10: Read and write strobes raised while select is low are ignored. No access takes place, `h_ack` stays high and the address does not move.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Processor clock |
| rst | input | 1 | Synchronous active-high reset |
| h_sel | input | 1 | Host select, asynchronous |
| h_latch | input | 1 | Host address-latch strobe, word captured on its fall |
| h_rd | input | 1 | Host read strobe |
| h_wr | input | 1 | Host write strobe |
| h_ad_in | input | 16 | Multiplexed address/data from host |
| h_ad_out | output | 16 | Read data to host |
| h_ad_oe | output | 1 | Host bus output enable (select and read) |
| h_ack | output | 1 | High when the port is free |
| h_ovl | output | 8 | Overlay selection register |
| mem_req | output | 1 | RAM access request |
| mem_we | output | 1 | RAM write enable |
| mem_is_dm | output | 1 | 1 selects DM, 0 selects PM |
| mem_addr | output | 14 | RAM word address |
| mem_wdata | output | 24 | RAM write data (DM uses bits 15:0) |
| mem_rdata | input | 24 | RAM read data, valid the clock after a read request |
| boot_host | input | 1 | Boot-through-host mode |
| core_run | output | 1 | Core release |

## Verification
The assertions assume a host that keeps `h_ad_in` stable from latch fall until the synchronized fall has been seen. They also assume the host keeps the write word stable while the write strobe is high, and raises no new strobe while `h_ack` is low. They further assume that `boot_host` stays constant after reset. The stimulus holds every strobe and bus value for several clocks, and it waits for the acknowledge to return before starting the next cycle. The RAM model answers reads one clock after the request, which matches the timing the port expects.

// File: rtl/host_port_pkg.sv
package host_port_pkg;

    localparam int BUS_W    = 16;
    localparam int ADDR_W   = 14;
    localparam int PM_W     = 24;
    localparam int OVL_W    = 8;
    localparam int LO_W     = PM_W - BUS_W;
    localparam int TYPE_BIT = ADDR_W;
    localparam int OVL_FLAG = BUS_W - 1;

    typedef enum logic [1:0] {
        ST_IDLE,
        ST_SYNC,
        ST_ACC,
        ST_DONE
    } xfer_state_e;

    typedef enum logic {
        MEM_PM = 1'b0,
        MEM_DM = 1'b1
    } mem_type_e;

    typedef struct packed {
        logic              is_ovl;
        logic              bad_ovl;
        mem_type_e         mtype;
        logic [ADDR_W-1:0] addr;
        logic [OVL_W-1:0]  ovl;
    } latch_word_t;

    function automatic latch_word_t decode_latch(input logic [BUS_W-1:0] w);
        latch_word_t r;
        r.is_ovl  = w[OVL_FLAG];
        r.bad_ovl = w[OVL_FLAG] && (w[OVL_FLAG-1:OVL_W] != '0);
        r.mtype   = mem_type_e'(w[TYPE_BIT]);
        r.addr    = w[ADDR_W-1:0];
        r.ovl     = w[OVL_W-1:0];
        return r;
    endfunction

endpackage

// File: rtl/host_sync.sv
module host_sync #(
    parameter int W      = 4,
    parameter int STAGES = 2
) (
    input  logic         clk,
    input  logic         rst,
    input  logic [W-1:0] d,
    output logic [W-1:0] q,
    output logic [W-1:0] q_prev
);
    logic [W-1:0] chain [STAGES+1];

    assign chain[0] = d;

    for (genvar s = 0; s < STAGES; s++) begin : g_stage
        always_ff @(posedge clk) begin
            if (rst) chain[s+1] <= '0;
            else     chain[s+1] <= chain[s];
        end
    end

    always_ff @(posedge clk) begin
        if (rst) q_prev <= '0;
        else     q_prev <= chain[STAGES];
    end

    assign q = chain[STAGES];
endmodule

// File: rtl/host_addr_regs.sv
module host_addr_regs
    import host_port_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              lat_ev,
    input  logic [BUS_W-1:0]  lat_word,
    input  logic              step,
    output logic [ADDR_W-1:0] addr,
    output mem_type_e         mtype,
    output logic [OVL_W-1:0]  ovl
);
    latch_word_t dec;
    assign dec = decode_latch(lat_word);

    always_ff @(posedge clk) begin
        if (rst) begin
            addr  <= '0;
            mtype <= MEM_PM;
            ovl   <= '0;
        end else if (lat_ev) begin
            if (!dec.is_ovl) begin
                addr  <= dec.addr;
                mtype <= dec.mtype;
            end else if (!dec.bad_ovl) begin
                ovl <= dec.ovl;
            end
        end else if (step) begin
            addr <= addr + 1'b1;
        end
    end
endmodule

// File: rtl/host_xfer_ctl.sv
module host_xfer_ctl
    import host_port_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              rd_ev,
    input  logic              wr_ev,
    input  logic              clr_phase,
    input  mem_type_e         mtype,
    input  logic [ADDR_W-1:0] addr,
    input  logic [BUS_W-1:0]  wdata_in,
    input  logic [PM_W-1:0]   mem_rdata,
    output logic              idle,
    output logic              mem_req,
    output logic              mem_we,
    output logic [PM_W-1:0]   mem_wdata,
    output logic [BUS_W-1:0]  dout,
    output logic              step,
    output logic              pm0_written
);
    xfer_state_e        state;
    logic               is_wr;
    logic               phase;
    logic [BUS_W-1:0]   wdata_q;
    logic [BUS_W-1:0]   hold_hi;
    logic [LO_W-1:0]    lo_keep;
    logic               need_mem;
    logic               is_dm;

    assign is_dm    = (mtype == MEM_DM);
    assign need_mem = is_dm || (is_wr ? phase : !phase);
    assign idle     = (state == ST_IDLE);
    assign mem_req  = (state == ST_ACC) && need_mem;
    assign mem_we   = is_wr;
    assign mem_wdata = is_dm ? {{LO_W{1'b0}}, wdata_q}
                             : {hold_hi, wdata_q[LO_W-1:0]};
    assign step        = (state == ST_DONE) && (is_dm || phase);
    assign pm0_written = (state == ST_DONE) && !is_dm && phase && is_wr
                         && (addr == '0);

    always_ff @(posedge clk) begin
        if (rst) begin
            state   <= ST_IDLE;
            is_wr   <= 1'b0;
            phase   <= 1'b0;
            wdata_q <= '0;
            hold_hi <= '0;
            lo_keep <= '0;
            dout    <= '0;
        end else begin
            unique case (state)
                ST_IDLE: begin
                    if (clr_phase) phase <= 1'b0;
                    if (rd_ev || wr_ev) begin
                        is_wr   <= wr_ev;
                        wdata_q <= wdata_in;
                        state   <= ST_SYNC;
                    end
                end
                ST_SYNC: state <= ST_ACC;
                ST_ACC:  state <= ST_DONE;
                ST_DONE: begin
                    state <= ST_IDLE;
                    if (is_dm) begin
                        if (!is_wr) dout <= mem_rdata[BUS_W-1:0];
                    end else if (!phase) begin
                        phase <= 1'b1;
                        if (is_wr) begin
                            hold_hi <= wdata_q;
                        end else begin
                            dout    <= mem_rdata[PM_W-1:LO_W];
                            lo_keep <= mem_rdata[LO_W-1:0];
                        end
                    end else begin
                        phase <= 1'b0;
                        if (!is_wr) dout <= {{(BUS_W-LO_W){1'b0}}, lo_keep};
                    end
                end
                default: state <= ST_IDLE;
            endcase
        end
    end
endmodule

// File: rtl/host_mem_port.sv
module host_mem_port
    import host_port_pkg::*;
#(
    parameter int SYNC_STAGES = 2
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              h_sel,
    input  logic              h_latch,
    input  logic              h_rd,
    input  logic              h_wr,
    input  logic [BUS_W-1:0]  h_ad_in,
    output logic [BUS_W-1:0]  h_ad_out,
    output logic              h_ad_oe,
    output logic              h_ack,
    output logic [OVL_W-1:0]  h_ovl,
    output logic              mem_req,
    output logic              mem_we,
    output logic              mem_is_dm,
    output logic [ADDR_W-1:0] mem_addr,
    output logic [PM_W-1:0]   mem_wdata,
    input  logic [PM_W-1:0]   mem_rdata,
    input  logic              boot_host,
    output logic              core_run
);
    localparam int N_STROBE = 4;

    logic [N_STROBE-1:0] s_now, s_prev;
    logic sel_q, lat_q, lat_p, rd_q, rd_p, wr_q, wr_p;
    logic lat_ev, rd_ev, wr_ev, idle, step, pm0_written;
    logic boot_done;
    mem_type_e mtype;

    host_sync #(.W(N_STROBE), .STAGES(SYNC_STAGES)) i_sync (
        .clk    (clk),
        .rst    (rst),
        .d      ({h_wr, h_rd, h_latch, h_sel}),
        .q      (s_now),
        .q_prev (s_prev)
    );

    assign {wr_q, rd_q, lat_q, sel_q} = s_now;
    assign wr_p  = s_prev[3];
    assign rd_p  = s_prev[2];
    assign lat_p = s_prev[1];

    assign lat_ev = idle && sel_q && lat_p && !lat_q;
    assign rd_ev  = sel_q && rd_q && !rd_p;
    assign wr_ev  = sel_q && wr_q && !wr_p;

    host_addr_regs i_regs (
        .clk      (clk),
        .rst      (rst),
        .lat_ev   (lat_ev),
        .lat_word (h_ad_in),
        .step     (step),
        .addr     (mem_addr),
        .mtype    (mtype),
        .ovl      (h_ovl)
    );

    host_xfer_ctl i_ctl (
        .clk         (clk),
        .rst         (rst),
        .rd_ev       (rd_ev),
        .wr_ev       (wr_ev),
        .clr_phase   (lat_ev),
        .mtype       (mtype),
        .addr        (mem_addr),
        .wdata_in    (h_ad_in),
        .mem_rdata   (mem_rdata),
        .idle        (idle),
        .mem_req     (mem_req),
        .mem_we      (mem_we),
        .mem_wdata   (mem_wdata),
        .dout        (h_ad_out),
        .step        (step),
        .pm0_written (pm0_written)
    );

    always_ff @(posedge clk) begin
        if (rst)              boot_done <= 1'b0;
        else if (pm0_written) boot_done <= 1'b1;
    end

    assign mem_is_dm = (mtype == MEM_DM);
    assign h_ack     = idle;
    assign h_ad_oe   = h_sel && h_rd;
    assign core_run  = !boot_host || boot_done;
endmodule

// File: rtl/host_mem_port_chk.sv
module host_mem_port_chk (
    input logic       clk,
    input logic       rst,
    input logic       h_ack,
    input logic [7:0] h_ovl,
    input logic       mem_req,
    input logic       lat_ev,
    input logic       boot_host,
    input logic       core_run
);
    a_r1_reset_state: assert property (@(posedge clk)
        rst |=> (h_ack && h_ovl == 8'h00));

    a_r7_busy_while_req: assert property (@(posedge clk) disable iff (rst)
        mem_req |-> !h_ack);

    a_r8_req_single: assert property (@(posedge clk) disable iff (rst)
        mem_req |=> !mem_req);

    a_r3_ovl_moves_on_latch: assert property (@(posedge clk) disable iff (rst)
        !$stable(h_ovl) |-> $past(lat_ev));

    a_r9_run_sticky: assert property (@(posedge clk) disable iff (rst)
        (boot_host && core_run) |=> core_run);
endmodule

bind host_mem_port host_mem_port_chk i_chk (
    .clk       (clk),
    .rst       (rst),
    .h_ack     (h_ack),
    .h_ovl     (h_ovl),
    .mem_req   (mem_req),
    .lat_ev    (lat_ev),
    .boot_host (boot_host),
    .core_run  (core_run)
);

// File: tb/test_host_mem_port.sv
module test_host_mem_port;
    localparam int CLK_PERIOD = 10;
    localparam int NVEC = 16;

    // op: 0 latch, 1 write, 2 read; {op, bus word, expected read}
    localparam logic [33:0] VEC [NVEC] = '{
        {2'd0, 16'h4010, 16'h0000},   // R2 DM 0x10
        {2'd1, 16'hBEEF, 16'h0000},   // R5
        {2'd1, 16'h1234, 16'h0000},   // R5
        {2'd0, 16'h4010, 16'h0000},
        {2'd2, 16'h0000, 16'hBEEF},   // R5
        {2'd2, 16'h0000, 16'h1234},   // R5 increment
        {2'd0, 16'h0005, 16'h0000},   // R2 PM 5
        {2'd1, 16'hABCD, 16'h0000},   // R6 high part
        {2'd1, 16'h00EF, 16'h0000},   // R6 low byte
        {2'd1, 16'h1122, 16'h0000},
        {2'd1, 16'h0033, 16'h0000},
        {2'd0, 16'h0005, 16'h0000},
        {2'd2, 16'h0000, 16'hABCD},   // R6
        {2'd2, 16'h0000, 16'h00EF},   // R6
        {2'd2, 16'h0000, 16'h1122},   // R6 address stepped once
        {2'd2, 16'h0000, 16'h0033}
    };

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        h_sel = 1'b0, h_latch = 1'b0, h_rd = 1'b0, h_wr = 1'b0;
    logic [15:0] h_ad_in = '0;
    logic [15:0] h_ad_out;
    logic        h_ad_oe, h_ack;
    logic [7:0]  h_ovl;
    logic        mem_req, mem_we, mem_is_dm;
    logic [13:0] mem_addr;
    logic [23:0] mem_wdata;
    logic [23:0] mem_rdata = '0;
    logic        boot_host = 1'b1;
    logic        core_run;

    int n_checks = 0;
    int n_fail = 0;

    logic [23:0] pm_ram [64];
    logic [15:0] dm_ram [64];

    always #(CLK_PERIOD/2) clk = ~clk;

    host_mem_port i_host_mem_port (
        .clk(clk), .rst(rst), .h_sel(h_sel), .h_latch(h_latch), .h_rd(h_rd),
        .h_wr(h_wr), .h_ad_in(h_ad_in), .h_ad_out(h_ad_out), .h_ad_oe(h_ad_oe),
        .h_ack(h_ack), .h_ovl(h_ovl), .mem_req(mem_req), .mem_we(mem_we),
        .mem_is_dm(mem_is_dm), .mem_addr(mem_addr), .mem_wdata(mem_wdata),
        .mem_rdata(mem_rdata), .boot_host(boot_host), .core_run(core_run)
    );

    initial begin
        for (int i = 0; i < 64; i++) begin
            pm_ram[i] = '0;
            dm_ram[i] = '0;
        end
    end

    always @(posedge clk) begin
        if (mem_req) begin
            if (mem_we) begin
                if (mem_is_dm) dm_ram[mem_addr[5:0]] <= mem_wdata[15:0];
                else           pm_ram[mem_addr[5:0]] <= mem_wdata;
            end else begin
                mem_rdata <= mem_is_dm ? {8'h00, dm_ram[mem_addr[5:0]]}
                                       : pm_ram[mem_addr[5:0]];
            end
        end
    end

    task automatic check(input string req, input logic [31:0] act,
                         input logic [31:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic wait_n(input int n);
        for (int i = 0; i < n; i++) @(negedge clk);
    endtask

    task automatic do_latch(input logic [15:0] w);
        @(negedge clk);
        h_sel = 1'b1; h_latch = 1'b1; h_ad_in = w;
        wait_n(4);
        h_latch = 1'b0;
        wait_n(4);
        h_sel = 1'b0;
        wait_n(2);
    endtask

    task automatic do_access(input logic wr, input logic sel,
                             input logic [15:0] w,
                             output logic saw_low, output int reqs,
                             output logic ack_end);
        saw_low = 1'b0;
        reqs = 0;
        @(negedge clk);
        h_sel = sel; h_ad_in = w;
        if (wr) h_wr = 1'b1; else h_rd = 1'b1;
        for (int i = 0; i < 8; i++) begin
            @(negedge clk);
            if (!h_ack) saw_low = 1'b1;
            if (mem_req) reqs++;
        end
        ack_end = h_ack;
        h_wr = 1'b0; h_rd = 1'b0;
        wait_n(4);
        h_sel = 1'b0;
        wait_n(1);
    endtask

    task automatic finish_run;
        $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fail);
        $finish;
    endtask

    initial begin
        #(CLK_PERIOD * 100000);
        n_checks++;
        n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        finish_run();
    end

    initial begin
        logic saw;
        int   rq;
        logic ackd;
        wait_n(3);
        rst = 1'b0;
        wait_n(1);
        check("R1 ack", 32'(h_ack), 32'd1);
        check("R1 ovl", 32'(h_ovl), 32'd0);
        check("R1 dout", 32'(h_ad_out), 32'd0);
        check("R1 core_run", 32'(core_run), 32'd0);

        for (int v = 0; v < NVEC; v++) begin
            logic [1:0]  op;
            logic [15:0] w, e;
            {op, w, e} = VEC[v];
            if (op == 2'd0) begin
                do_latch(w);
                check("R2 ack after latch", 32'(h_ack), 32'd1);
            end else if (op == 2'd1) begin
                do_access(1'b1, 1'b1, w, saw, rq, ackd);
                check("R7 write ack cycle", {30'd0, saw, ackd}, 32'd3);
            end else begin
                do_access(1'b0, 1'b1, w, saw, rq, ackd);
                check("R5/R6 read data", 32'(h_ad_out), 32'(e));
            end
        end
        check("R9 still held", 32'(core_run), 32'd0);

        do_latch(16'h4011);
        do_latch(16'h805A);
        check("R3 overlay load", 32'(h_ovl), 32'h5A);
        do_latch(16'h8100);
        check("R4 bad overlay ignored", 32'(h_ovl), 32'h5A);
        do_access(1'b0, 1'b1, 16'h0, saw, rq, ackd);
        check("R3/R4 address kept", 32'(h_ad_out), 32'h1234);

        do_latch(16'h4010);
        do_access(1'b0, 1'b0, 16'h0, saw, rq, ackd);
        check("R10 unselected no ack drop", {30'd0, saw, ackd}, 32'd1);
        check("R10 unselected no request", 32'(rq), 32'd0);
        do_access(1'b0, 1'b1, 16'h0, saw, rq, ackd);
        check("R10 address not moved", 32'(h_ad_out), 32'hBEEF);
        check("R8 DM read one request", 32'(rq), 32'd1);

        do_latch(16'h0000);
        do_access(1'b1, 1'b1, 16'h0102, saw, rq, ackd);
        check("R8 PM write first no request", 32'(rq), 32'd0);
        check("R9 held after first half", 32'(core_run), 32'd0);
        do_access(1'b1, 1'b1, 16'h0003, saw, rq, ackd);
        check("R8 PM write second one request", 32'(rq), 32'd1);
        check("R9 released", 32'(core_run), 32'd1);
        do_latch(16'h0000);
        do_access(1'b0, 1'b1, 16'h0, saw, rq, ackd);
        check("R6 PM0 high", 32'(h_ad_out), 32'h0102);
        check("R8 PM read first one request", 32'(rq), 32'd1);
        do_access(1'b0, 1'b1, 16'h0, saw, rq, ackd);
        check("R6 PM0 low", 32'(h_ad_out), 32'h0003);
        check("R8 PM read second no request", 32'(rq), 32'd0);
        check("R9 stays released", 32'(core_run), 32'd1);

        finish_run();
    end
endmodule